// File: doc/BRIEF.md
# Scratchpad Address Remapping Table

This block sits on a processor's data port, in front of two targets: an on-chip scratchpad RAM and the path to external memory. It keeps a small table of open objects. Each entry holds a logical base, a byte size, a placement base inside the scratchpad, a valid bit and a read-only bit. Every load or store address is compared against all entries at once. An address inside a valid entry is sent to the scratchpad at `address - logical base + scratchpad base`. Any other address goes to external memory unchanged. The program keeps using the same logical address whether or not the object currently lives on chip.

Software opens and closes objects at any time by writing entry fields by index through a small configuration port. Objects may be placed anywhere in the scratchpad, and open objects may overlap in logical space. Overlaps are resolved by fixed index priority. Stores never land in a read-only copy: they go to the first writable match, or to external memory if there is none. The lookup result, the chosen entry index and the translated address appear in the same cycle as the request. Copying object contents between the memories is the job of software.

Top module: `spm_remap`

## Requirements
- R1: After reset every entry is invalid, so every request misses, `ext_valid` rises and `out_addr` equals `req_addr`.
- R2: An entry matches when its valid bit is set and the address satisfies base <= addr < base + size, compared unsigned. The address base + size does not match, and neither does base - 4.
- R3: On a scratchpad hit, `out_addr` is the low SPW bits of (addr - logical base + scratchpad base), zero-extended, and `hit_idx` names the chosen entry.
- R4: On a miss, `ext_valid` is high, `spm_hit` is low and `out_addr` equals `req_addr`. `spm_hit` and `ext_valid` are never high together.
- R5: A load (`req_write` = 0) that matches several valid entries selects the lowest-numbered one.
- R6: A store (`req_write` = 1) selects the lowest-numbered matching entry whose read-only bit is clear. A store whose only matches are read-only goes to external memory with its address unchanged.
- R7: The range test never wraps. An entry whose base + size exceeds 2^32 matches only addresses from its base to 0xFFFFFFFF, never low addresses.
- R8: A configuration write happens on the rising clock edge when `cfg_we` is high, and is visible from that edge on. Field codes are 0 logical base, 1 size, 2 scratchpad base and 3 flags (bit 0 valid, bit 1 read-only). Bits [1:0] of written bases and sizes are stored as zero.
- R9: Clearing the valid bit of one entry closes it, so its range misses from the next edge. Other entries are unaffected.
- R10: While `req_valid` is low, `spm_hit` and `ext_valid` are both low.
- R11: Lookup outputs depend combinationally on the request and the table state, with no clock edge needed between request and result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Entry index written |
| cfg_fld | input | 2 | Field code (0 lbase, 1 size, 2 sbase, 3 flags) |
| cfg_wdata | input | 32 | Field value |
| req_valid | input | 1 | Processor access present |
| req_write | input | 1 | Access is a store |
| req_addr | input | 32 | Logical address of the access |
| spm_hit | output | 1 | Access steered to the scratchpad |
| ext_valid | output | 1 | Access steered to external memory |
| hit_idx | output | 3 | Entry chosen on a hit, zero otherwise |
| out_addr | output | 32 | Scratchpad address on a hit, logical address on a miss |

## Verification
Lookup results are due in the same cycle as the request. The bench drives each request just after a falling edge and samples 1 ns later, well before the next rising edge, so no clock edge falls between stimulus and check. A configuration write takes effect only at the rising edge that samples it. One check therefore deliberately samples the lookup while a flags write is pending, before that edge, and expects the old result. The same address is checked again just after the edge and must then show the new one. A sweep compares many addresses against a reference table kept in the bench. Directed checks pin down the range boundaries, wrap, overlap priority and read-only steering.

// File: rtl/spm_remap_pkg.sv
`timescale 1ns/1ps
package spm_remap_pkg;
    typedef enum logic [1:0] {
        FLD_LBASE = 2'd0,
        FLD_SIZE  = 2'd1,
        FLD_SBASE = 2'd2,
        FLD_FLAGS = 2'd3
    } cfg_fld_e;

    localparam int FLAG_VLD_BIT = 0;
    localparam int FLAG_RO_BIT  = 1;
endpackage

// File: rtl/spm_remap_table.sv
`timescale 1ns/1ps
module spm_remap_table
    import spm_remap_pkg::*;
#(
    parameter int N   = 8,
    parameter int AW  = 32,
    parameter int SPW = 16,
    parameter int IW  = $clog2(N)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [IW-1:0]           cfg_idx,
    input  cfg_fld_e                cfg_fld,
    input  logic [AW-1:0]           cfg_wdata,
    output logic [N-1:0][AW-1:0]    lbase_o,
    output logic [N-1:0][AW-1:0]    size_o,
    output logic [N-1:0][SPW-1:0]   sbase_o,
    output logic [N-1:0]            vld_o,
    output logic [N-1:0]            ro_o
);
    typedef struct packed {
        logic [AW-1:0]  lbase;
        logic [AW-1:0]  size;
        logic [SPW-1:0] sbase;
        logic           vld;
        logic           ro;
    } ent_t;

    typedef struct packed {
        ent_t [N-1:0] ent;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    logic [AW-1:0] wdata_al;
    assign wdata_al = {cfg_wdata[AW-1:2], 2'b00};

    always_comb begin
        tbl_d = tbl_q;
        if (cfg_we && (int'(cfg_idx) < N)) begin
            unique case (cfg_fld)
                FLD_LBASE: tbl_d.ent[cfg_idx].lbase = wdata_al;
                FLD_SIZE:  tbl_d.ent[cfg_idx].size  = wdata_al;
                FLD_SBASE: tbl_d.ent[cfg_idx].sbase = {wdata_al[SPW-1:2], 2'b00};
                FLD_FLAGS: begin
                    tbl_d.ent[cfg_idx].vld = cfg_wdata[FLAG_VLD_BIT];
                    tbl_d.ent[cfg_idx].ro  = cfg_wdata[FLAG_RO_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_out
        assign lbase_o[g] = tbl_q.ent[g].lbase;
        assign size_o[g]  = tbl_q.ent[g].size;
        assign sbase_o[g] = tbl_q.ent[g].sbase;
        assign vld_o[g]   = tbl_q.ent[g].vld;
        assign ro_o[g]    = tbl_q.ent[g].ro;
    end

    // Valid bits only change through a configuration write (R8, R9)
    p_valid_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(vld_o));

    // An entry not addressed by a write keeps its fields (R9)
    p_other_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_idx != '0) |=> $stable(lbase_o[0]) && $stable(size_o[0]) && $stable(vld_o[0]));

    // Stored sizes keep their two low bits clear (R8)
    for (genvar g = 0; g < N; g++) begin : g_chk
        p_size_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
            size_o[g][1:0] == 2'b00);
    end
endmodule

// File: rtl/spm_remap_match.sv
`timescale 1ns/1ps
module spm_remap_match #(
    parameter int N  = 8,
    parameter int AW = 32
) (
    input  logic [AW-1:0]         addr,
    input  logic [N-1:0][AW-1:0]  lbase,
    input  logic [N-1:0][AW-1:0]  size,
    input  logic [N-1:0]          vld,
    output logic [N-1:0]          hit
);
    for (genvar g = 0; g < N; g++) begin : g_ent
        logic          above;
        logic [AW-1:0] off;
        // Offset is taken only once addr >= base, so no sum can wrap.
        assign above  = (addr >= lbase[g]);
        assign off    = addr - lbase[g];
        assign hit[g] = vld[g] && above && (off < size[g]);
    end
endmodule

// File: rtl/spm_remap_pick.sv
`timescale 1ns/1ps
module spm_remap_pick #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/spm_remap.sv
`timescale 1ns/1ps
module spm_remap
    import spm_remap_pkg::*;
#(
    parameter int N   = 8,
    parameter int AW  = 32,
    parameter int SPW = 16,
    localparam int IW  = $clog2(N),
    localparam int PADW = AW - SPW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [IW-1:0] cfg_idx,
    input  logic [1:0]    cfg_fld,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    output logic          spm_hit,
    output logic          ext_valid,
    output logic [IW-1:0] hit_idx,
    output logic [AW-1:0] out_addr
);
    logic [N-1:0][AW-1:0]  lbase;
    logic [N-1:0][AW-1:0]  size;
    logic [N-1:0][SPW-1:0] sbase;
    logic [N-1:0]          vld;
    logic [N-1:0]          ro;
    logic [N-1:0]          match;

    spm_remap_table #(.N(N), .AW(AW), .SPW(SPW), .IW(IW)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_fld   (cfg_fld_e'(cfg_fld)),
        .cfg_wdata (cfg_wdata),
        .lbase_o   (lbase),
        .size_o    (size),
        .sbase_o   (sbase),
        .vld_o     (vld),
        .ro_o      (ro)
    );

    spm_remap_match #(.N(N), .AW(AW)) u_match (
        .addr  (req_addr),
        .lbase (lbase),
        .size  (size),
        .vld   (vld),
        .hit   (match)
    );

    logic          ld_found, st_found;
    logic [IW-1:0] ld_idx, st_idx;

    spm_remap_pick #(.N(N), .IW(IW)) u_pick_ld (
        .req   (match),
        .found (ld_found),
        .idx   (ld_idx)
    );

    spm_remap_pick #(.N(N), .IW(IW)) u_pick_st (
        .req   (match & ~ro),
        .found (st_found),
        .idx   (st_idx)
    );

    logic           sel_found;
    logic [IW-1:0]  sel_idx;
    logic [AW-1:0]  sel_off;
    logic [SPW-1:0] spm_addr;

    always_comb begin
        sel_found = req_write ? st_found : ld_found;
        sel_idx   = req_write ? st_idx   : ld_idx;
        sel_off   = req_addr - lbase[sel_idx];
        spm_addr  = sel_off[SPW-1:0] + sbase[sel_idx];
        spm_hit   = req_valid && sel_found;
        ext_valid = req_valid && !sel_found;
        hit_idx   = sel_found ? sel_idx : '0;
        out_addr  = sel_found ? {{PADW{1'b0}}, spm_addr} : req_addr;
    end

    function automatic logic [N-1:0] below(input logic [IW-1:0] k);
        below = (N'(1) << k) - N'(1);
    endfunction

    // One target at most per access (R4)
    p_one_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(spm_hit && ext_valid));

    // Miss path passes the address through (R4)
    p_miss_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ext_valid |-> out_addr == req_addr);

    // Loads pick the lowest matching entry (R5)
    p_lowest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (spm_hit && !req_write) |-> match[hit_idx] && ((match & below(hit_idx)) == '0));

    // Stores never land in a read-only entry (R6)
    p_ro_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (spm_hit && req_write) |-> !ro[hit_idx] && match[hit_idx]);

    // Idle request drives no target (R10)
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !spm_hit && !ext_valid);
endmodule

// File: tb/spm_remap_tb.sv
`timescale 1ns/1ps
module spm_remap_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [1:0]  cfg_fld = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic        spm_hit, ext_valid;
    logic [2:0]  hit_idx;
    logic [31:0] out_addr;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [31:0] r_lb [8];
    logic [31:0] r_sz [8];
    logic [15:0] r_sb [8];
    logic        r_v  [8];
    logic        r_ro [8];

    always #2.5 clk = ~clk;

    spm_remap u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_fld(cfg_fld), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .spm_hit(spm_hit),
        .ext_valid(ext_valid), .hit_idx(hit_idx), .out_addr(out_addr)
    );

    task automatic cfg_write(input int idx, input int fld, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_fld = 2'(fld); cfg_wdata = d;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        case (fld)
            0: r_lb[idx] = {d[31:2], 2'b00};
            1: r_sz[idx] = {d[31:2], 2'b00};
            2: r_sb[idx] = {d[15:2], 2'b00};
            default: begin r_v[idx] = d[0]; r_ro[idx] = d[1]; end
        endcase
    endtask

    task automatic open_ent(input int idx, input logic [31:0] lb, input logic [31:0] sz,
                            input logic [31:0] sb, input bit ro);
        cfg_write(idx, 0, lb);
        cfg_write(idx, 1, sz);
        cfg_write(idx, 2, sb);
        cfg_write(idx, 3, {30'd0, ro, 1'b1});
    endtask

    task automatic compare(input string tag, input logic [1:0] st, input logic [2:0] idx,
                           input logic [31:0] a, input logic [1:0] est,
                           input logic [2:0] eidx, input logic [31:0] ea);
        total++;
        if (st !== est || idx !== eidx || a !== ea) begin
            bad++;
            $display("FAIL %s: got hit/ext=%b idx=%0d addr=%h, expected hit/ext=%b idx=%0d addr=%h",
                     tag, st, idx, a, est, eidx, ea);
        end
    endtask

    // Drive a request just after the falling edge, sample 1 ns later (same cycle).
    task automatic look(input string tag, input logic [31:0] addr, input bit we,
                        input bit ehit, input logic [2:0] eidx, input logic [31:0] ea);
        @(negedge clk);
        req_valid = 1'b1; req_write = we; req_addr = addr;
        #1;
        compare(tag, {spm_hit, ext_valid}, hit_idx, out_addr,
                {ehit, ~ehit}, ehit ? eidx : 3'd0, ea);
    endtask

    task automatic ref_look(input logic [31:0] addr, input bit we,
                            output bit h, output logic [2:0] i, output logic [31:0] a);
        h = 0; i = 0; a = addr;
        for (int k = 7; k >= 0; k--) begin
            logic [32:0] top;
            top = {1'b0, r_lb[k]} + {1'b0, r_sz[k]};
            if (r_v[k] && !(we && r_ro[k]) && addr >= r_lb[k] && {1'b0, addr} < top) begin
                h = 1; i = 3'(k);
                a = {16'd0, 16'(addr - r_lb[k]) + r_sb[k]};
            end
        end
    endtask

    task automatic t_reset();
        look("R1 reset miss", 32'h0000_1000, 0, 0, 0, 32'h0000_1000);
        look("R1 reset miss store", 32'hFFFF_FFFC, 1, 0, 0, 32'hFFFF_FFFC);
    endtask

    task automatic t_basic();
        open_ent(0, 32'h0000_1000, 32'h100, 32'h0200, 0);
        look("R2 base hits", 32'h0000_1000, 0, 1, 0, 32'h0000_0200);
        look("R3 R11 last word", 32'h0000_10FC, 0, 1, 0, 32'h0000_02FC);
        look("R2 end misses", 32'h0000_1100, 0, 0, 0, 32'h0000_1100);
        look("R2 R4 below misses", 32'h0000_0FFC, 1, 0, 0, 32'h0000_0FFC);
    endtask

    task automatic t_reloc();
        open_ent(3, 32'h8000_0010, 32'h40, 32'h7FF0, 0);
        look("R3 relocation", 32'h8000_0020, 0, 1, 3, 32'h0000_8000);
    endtask

    task automatic t_overlap();
        open_ent(5, 32'h0000_1080, 32'h100, 32'h4000, 0);
        open_ent(2, 32'h0000_1080, 32'h20, 32'h6000, 1);
        look("R5 lowest of 0/2/5", 32'h0000_1090, 0, 1, 0, 32'h0000_0290);
        look("R5 only 5", 32'h0000_1104, 0, 1, 5, 32'h0000_4084);
        look("R6 store to writable 0", 32'h0000_1090, 1, 1, 0, 32'h0000_0290);
    endtask

    task automatic t_close();
        cfg_write(0, 3, 32'h0);
        look("R9 closed range misses", 32'h0000_1000, 0, 0, 0, 32'h0000_1000);
        look("R9 R6 store skips ro 2", 32'h0000_1090, 1, 1, 5, 32'h0000_4010);
        look("R5 load takes ro 2", 32'h0000_1090, 0, 1, 2, 32'h0000_6010);
        look("R9 entry 3 kept", 32'h8000_0010, 0, 1, 3, 32'h0000_7FF0);
    endtask

    task automatic t_readonly();
        open_ent(6, 32'h0000_2000, 32'h10, 32'h0100, 1);
        look("R6 ro-only store external", 32'h0000_2004, 1, 0, 0, 32'h0000_2004);
        look("R6 ro load hits", 32'h0000_2004, 0, 1, 6, 32'h0000_0104);
    endtask

    task automatic t_wrap();
        open_ent(7, 32'hFFFF_FF00, 32'h200, 32'h3000, 0);
        look("R7 top word hits", 32'hFFFF_FFFC, 0, 1, 7, 32'h0000_30FC);
        look("R7 no wrap to low", 32'h0000_0010, 0, 0, 0, 32'h0000_0010);
    endtask

    task automatic t_cfg();
        cfg_write(1, 0, 32'h0000_5003);
        cfg_write(1, 1, 32'h0000_0043);
        cfg_write(1, 2, 32'h0000_0000);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'd1; cfg_fld = 2'd3; cfg_wdata = 32'h1;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h0000_5000;
        #1;
        compare("R8 before edge", {spm_hit, ext_valid}, hit_idx, out_addr, 2'b01, 3'd0, 32'h0000_5000);
        @(posedge clk);
        #1;
        cfg_we = 1'b0; r_v[1] = 1; r_ro[1] = 0;
        compare("R8 after edge", {spm_hit, ext_valid}, hit_idx, out_addr, 2'b10, 3'd1, 32'h0000_0000);
        look("R8 size low bits dropped", 32'h0000_503C, 0, 1, 1, 32'h0000_003C);
        look("R8 R2 size end", 32'h0000_5040, 0, 0, 0, 32'h0000_5040);
    endtask

    task automatic t_idle();
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_addr = 32'h0000_5000;
        #1;
        total++;
        if (spm_hit !== 1'b0 || ext_valid !== 1'b0) begin
            bad++;
            $display("FAIL R10 idle: got hit=%b ext=%b, expected 0 0", spm_hit, ext_valid);
        end
    endtask

    task automatic t_sweep();
        bit h; logic [2:0] i; logic [31:0] a;
        for (int k = 0; k < 96; k++) begin
            logic [31:0] ad;
            ad = (k < 80) ? 32'h0000_0FF0 + 32'(k * 8) : 32'hFFFF_FEF8 + 32'((k - 80) * 4);
            ref_look(ad, k[0], h, i, a);
            look("R2 R3 R5 R6 sweep", ad, k[0], h, i, a);
        end
    endtask

    initial begin
        for (int k = 0; k < 8; k++) begin
            r_lb[k] = 0; r_sz[k] = 0; r_sb[k] = 0; r_v[k] = 0; r_ro[k] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_basic();
        t_reloc();
        t_overlap();
        t_close();
        t_readonly();
        t_wrap();
        t_cfg();
        t_idle();
        t_sweep();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule